// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Idle Default Owner and Burst Slot Limit

This block sits in front of one shared slave and decides which of five bus masters owns it. Each master raises a request line. The current owner also raises a last-beat flag on the final transfer cycle of its burst. Among the masters that request, ownership rotates in round-robin order. An owner keeps the slave until its burst ends or it drops its request.

When nobody requests, a two-bit policy input selects what happens to the grant. It can be released to nobody, left with the master that most recently won arbitration, or parked on a master number chosen by configuration. Parking the grant lets that master start a burst without first waiting a cycle for arbitration.

A slot limit input stops one master from holding the slave for too long. While another master is waiting, the owner gets at most that many consecutive transfer cycles. After that the arbiter takes the slave away and offers it to the next requester. Writing a limit of zero turns this check off. The grant is registered, so a decision made from the inputs in one cycle shows on the grant output in the next cycle.

Top module: `rr_default_arbiter`

## Requirements
- R1: While rst_n is low, grant is all-zero.
- R2: grant has at most one bit set in every cycle.
- R3: When the arbiter re-arbitrates and at least one master requests, the winner is the first requesting master found by searching upward from the master after the previous winner. The search wraps from master 4 to master 0. After reset the search starts at master 0.
- R4: The grant is registered. The inputs sampled at one rising edge decide the grant that is visible after that edge.
- R5: While the owner keeps its request high, does not assert its last-beat bit, and its slot has not expired, the grant does not change. The arbiter re-arbitrates when the owner asserts its last-beat bit, when the owner drops its request, or when there is no owner.
- R6: With dflt_mode code 0 or 3, re-arbitration with no request pending gives an all-zero grant.
- R7: With dflt_mode code 1, re-arbitration with no request pending grants the master that last won arbitration. Before any master has won, that is master 0.
- R8: With dflt_mode code 2, re-arbitration with no request pending grants the master numbered dflt_id. If dflt_id is 5 or more, the grant is all-zero.
- R9: With a slot limit L greater than 0, an owner that holds its request while another master requests gets at most L consecutive transfer cycles. The next owner is then chosen under R3.
- R10: With a slot limit of 0, no burst is ever broken, whatever other masters request.
- R11: The slot count reloads from slot_limit at every re-arbitration. If the count runs out while no other master requests, the owner keeps the grant. The burst is then broken in the first cycle in which another master requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Request line of each master, bit i for master i |
| last_beat | input | 5 | Per-master flag marking the final transfer cycle of a burst |
| dflt_mode | input | 2 | Idle policy: 0 or 3 none, 1 last winner, 2 fixed master |
| dflt_id | input | 3 | Master number parked on the slave under policy 2 |
| slot_limit | input | 8 | Maximum consecutive transfer cycles while others wait; 0 disables |
| grant | output | 5 | One-hot or all-zero grant to the masters |

## Verification
Slot expiry and the end of a burst can fall in the same cycle. To provoke this, the bench runs a burst with a limit of 2 while another master waits, and raises the owner's last-beat bit on exactly the second transfer cycle. The check requires a single hand-over to the waiting master in round-robin order. It also requires that the new owner then receives a full fresh slot of two cycles, which shows that the counter was reloaded and not decremented twice. Random traffic repeats this overlap and the overlap of expiry with a dropped request. Every cycle of that traffic is compared against the scoreboard's expected grant.

// File: rtl/rr_default_arbiter.sv
module rr_default_arbiter #(
  parameter int N      = 5,
  parameter int SLOT_W = 8,
  localparam int IDW   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req,
  input  logic [N-1:0]      last_beat,
  input  logic [1:0]        dflt_mode,
  input  logic [IDW-1:0]    dflt_id,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic [N-1:0]      grant
);
  localparam logic [IDW-1:0] TOP_ID = IDW'(N - 1);
  localparam logic [N-1:0]   ONE    = N'(1);

  logic [IDW-1:0]    ptr, last_id, win_id;
  logic              win_any;
  logic [SLOT_W-1:0] cnt;
  logic [N-1:0]      nxt;

  wire owner_busy = |(grant & req);
  wire owner_last = |(grant & req & last_beat);
  wire others     = |(req & ~grant);
  wire expired    = (slot_limit != '0) && (cnt <= SLOT_W'(1));
  wire rearb      = !owner_busy || owner_last || (expired && others);

  always_comb begin
    win_any = 1'b0;
    win_id  = '0;
    for (int k = 0; k < N; k++) begin
      int t;
      t = int'(ptr) + k;
      if (t >= N) t = t - N;
      if (!win_any && req[t]) begin
        win_any = 1'b1;
        win_id  = IDW'(t);
      end
    end
  end

  always_comb begin
    if (win_any) nxt = ONE << win_id;
    else begin
      case (dflt_mode)
        2'd1:    nxt = ONE << last_id;
        2'd2:    nxt = (dflt_id <= TOP_ID) ? (ONE << dflt_id) : '0;
        default: nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant   <= '0;
      ptr     <= '0;
      last_id <= '0;
      cnt     <= '0;
    end else if (rearb) begin
      grant <= nxt;
      cnt   <= slot_limit;
      if (win_any) begin
        last_id <= win_id;
        ptr     <= (win_id == TOP_ID) ? '0 : win_id + 1'b1;
      end
    end else if (owner_busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_hold_no_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(grant & req)) && !(|(grant & req & last_beat)) && slot_limit == '0) |=> $stable(grant));

  assert_idle_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && (dflt_mode == 2'd0 || dflt_mode == 2'd3)) |=> grant == '0);

  assert_idle_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && dflt_mode == 2'd2 && dflt_id <= TOP_ID) |=> grant == (ONE << $past(dflt_id)));

  assert_win_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0 && grant == '0) |=> (grant & $past(req)) != '0);
endmodule

// File: tb/rr_default_arbiter_bench.sv
`timescale 1ns/1ps
module rr_default_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req = '0, last_beat = '0;
  logic [1:0] dflt_mode = '0;
  logic [2:0] dflt_id = '0;
  logic [7:0] slot_limit = '0;
  logic [4:0] grant;

  rr_default_arbiter u_rr_default_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .last_beat(last_beat),
    .dflt_mode(dflt_mode), .dflt_id(dflt_id), .slot_limit(slot_limit), .grant(grant));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [4:0] q_exp[$];
  string      q_tag[$];

  logic [4:0] m_g = '0;
  int m_ptr = 0, m_last = 0, m_cnt = 0;

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [4:0] r, input logic [4:0] lb, input logic [1:0] md,
                      input logic [2:0] id, input logic [7:0] lim, input string tag);
    logic busy, lastb, oth, exp_, rearb, found;
    int win;
    logic [4:0] nx;
    @(negedge clk);
    req = r; last_beat = lb; dflt_mode = md; dflt_id = id; slot_limit = lim;
    busy  = |(m_g & r);
    lastb = |(m_g & r & lb);
    oth   = |(r & ~m_g);
    exp_  = (lim != 0) && (m_cnt <= 1);
    rearb = !busy || lastb || (exp_ && oth);
    found = 0; win = 0;
    for (int k = 0; k < 5; k++) if (!found && r[(m_ptr + k) % 5]) begin found = 1; win = (m_ptr + k) % 5; end
    nx = m_g;
    if (rearb) begin
      if (found) nx = 5'b1 << win;
      else if (md == 2'd1) nx = 5'b1 << m_last;
      else if (md == 2'd2) nx = (id < 5) ? (5'b1 << id) : 5'b0;
      else nx = 5'b0;
      m_cnt = lim;
      if (found) begin m_last = win; m_ptr = (win + 1) % 5; end
    end else if (busy && m_cnt != 0) m_cnt = m_cnt - 1;
    m_g = nx;
    q_exp.push_back(nx);
    q_tag.push_back(tag);
  endtask

  initial forever begin
    @(posedge clk);
    #1;
    if (q_exp.size() > 0) begin
      logic [4:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(grant, e, t);
      if ($countones(grant) > 1) begin
        errors++;
        $display("FAIL R2: grant=%b expected one-hot or zero", grant);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant, 5'b0, "R1 reset");
    rst_n = 1'b1;

    repeat (2) step(5'b00000, 5'b0, 2'd0, 3'd0, 8'd0, "R6 idle none");
    step(5'b00100, 5'b0, 2'd0, 3'd0, 8'd0, "R4 first grant m2");
    step(5'b00100, 5'b0, 2'd0, 3'd0, 8'd0, "R5 hold m2");
    repeat (3) step(5'b10101, 5'b0, 2'd0, 3'd0, 8'd0, "R10 no break with others waiting");
    step(5'b10101, 5'b00100, 2'd0, 3'd0, 8'd0, "R3 m2 last beat, next m4");
    step(5'b10101, 5'b10000, 2'd0, 3'd0, 8'd0, "R3 wrap to m0");
    step(5'b10100, 5'b0, 2'd0, 3'd0, 8'd0, "R5 m0 drop, next m2");
    step(5'b00000, 5'b0, 2'd1, 3'd0, 8'd0, "R7 idle last winner");
    step(5'b00000, 5'b0, 2'd2, 3'd3, 8'd0, "R8 idle fixed m3");
    step(5'b00000, 5'b0, 2'd2, 3'd6, 8'd0, "R8 fixed id out of range");
    step(5'b00000, 5'b0, 2'd3, 3'd3, 8'd0, "R6 mode 3 none");
    repeat (5) step(5'b01010, 5'b0, 2'd0, 3'd0, 8'd3, "R9 slot limit 3");
    repeat (4) step(5'b01000, 5'b0, 2'd0, 3'd0, 8'd2, "R11 expiry without others");
    step(5'b01001, 5'b0, 2'd0, 3'd0, 8'd2, "R11 break on new request");
    step(5'b01001, 5'b0, 2'd0, 3'd0, 8'd2, "R11 new owner m0");
    step(5'b00011, 5'b0, 2'd0, 3'd0, 8'd2, "R9 m1 takes over");
    step(5'b01010, 5'b0, 2'd0, 3'd0, 8'd2, "R9 m1 beat 1");
    step(5'b01010, 5'b00010, 2'd0, 3'd0, 8'd2, "R9 expiry with last beat");
    repeat (3) step(5'b01010, 5'b0, 2'd0, 3'd0, 8'd2, "R11 fresh slot after overlap");
    for (int i = 0; i < 400; i++) begin
      logic [4:0] r, lb;
      r  = 5'($urandom);
      lb = ($urandom % 4 == 0) ? 5'($urandom) : 5'b0;
      step(r, lb, 2'($urandom), 3'($urandom % 7), 8'($urandom % 5), "R2 random traffic");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule